// File: doc/BRIEF.md
# Debug FIFO Bypass Access Port

This block gives a host direct access to a bank of tagged packet FIFOs through a 32-bit word-addressed slave interface, so that software can load or drain the FIFOs without the DMA engines or the serial link. Each FIFO entry holds 33 bits: a 32-bit data word and a one-bit tag. The data word travels over the 32-bit bus. The tag goes in through an address bit on writes. On reads it comes out through a bit of a status word.

The bank holds three transmit-side FIFOs and three receive-side FIFOs. On the receive side, one FIFO is a combined FIFO twice as deep as the others. Debug access works only while `dbg_mode` is high. In that state the block also holds down the arbitration requests that would let the link transmitter or the receive DMA start draining the FIFOs. The host must read the status word after a FIFO data read to learn the tag of the word it popped.

Top module: `dbg_fifo_port`

## Requirements
- R1: The port carries word address bits 5 down to 2 only. Bits 4:2 form a select code: codes 0, 1 and 2 are the transmit FIFOs, code 3 is the combined receive FIFO, and codes 4 and 5 are the receive sub-FIFOs. Reads and writes use the same code, and each FIFO returns its words in first-in first-out order.
- R2: On an accepted write, address bit 5 is stored as the entry's tag: 1 stores tag 1 and 0 stores tag 0.
- R3: After a read request in cycle N that pops a word, `hst_rdata` shows the popped data in cycle N+1. In the same cycle, bit 6 of `stat_reg` shows the popped tag. All other bits of `stat_reg` read as zero at all times.
- R4: The latched tag in `stat_reg[6]` keeps its value until the next read that pops a word.
- R5: A read of an empty FIFO returns zero on `hst_rdata` in the next cycle, pops nothing and leaves `stat_reg` unchanged.
- R6: Each transmit FIFO and each receive sub-FIFO holds `TX_DEPTH` or `RX_SUB_DEPTH` words, and the combined receive FIFO holds `RX_COMB_DEPTH` words. A write to a full FIFO is dropped.
- R7: Select codes 6 and 7 ignore writes and read as zero.
- R8: While `dbg_mode` is low, host reads and writes are ignored: nothing is pushed or popped, `hst_rdata` stays zero and `stat_reg` is unchanged.
- R9: `arb_req_tx` is high exactly when `dbg_mode` is low and at least one transmit FIFO (codes 0 to 2) holds a word. `arb_req_rx` is high exactly when `dbg_mode` is low and at least one receive FIFO (codes 3 to 5) holds a word.
- R10: When `hst_rd` and `hst_wr` are both high in the same cycle, only the read takes effect and the write is discarded.
- R11: `hst_rdata` is zero in every cycle that does not directly follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_mode | input | 1 | Enables host access and blocks the normal requests |
| hst_addr | input | 4 | Word address bits 5:2 (bit 5 is the write tag, bits 4:2 the select code) |
| hst_wr | input | 1 | Write strobe, one cycle per word |
| hst_rd | input | 1 | Read strobe, one cycle per word |
| hst_wdata | input | 32 | Write data |
| hst_rdata | output | 32 | Read data, valid the cycle after `hst_rd` |
| stat_reg | output | 32 | Status word; bit 6 is the last popped tag |
| arb_req_tx | output | 1 | Request toward the link transmitter |
| arb_req_rx | output | 1 | Request toward the receive DMA |

## Verification
A wrong pointer or count inside a FIFO shows up at the ports as a word returned out of order, a drain sequence that is too long or too short, or a zero that arrives early. Each of these appears on `hst_rdata` one cycle after the read request that exposes it. A wrong tag path shows up in `stat_reg[6]` in that same cycle. A stale or missing empty flag shows up at once on `arb_req_tx` or `arb_req_rx` when `dbg_mode` drops. The bench fills every select code past its depth, with both tag values, and then drains every code past empty, so each of these faults appears within one fill-and-drain pass.

// File: rtl/dbgf_pkg.sv
// Package: shared constants and entry type for the debug FIFO bypass port.
// Assumes a fixed bank of six FIFOs behind a three-bit select code.
package dbgf_pkg;
    localparam int DATA_W    = 32;
    localparam int SEL_W     = 3;
    localparam int NUM_FIFO  = 6;
    localparam int TX_COUNT  = 3;
    localparam int STAT_TAG  = 6;

    typedef struct packed {
        logic              tag;
        logic [DATA_W-1:0] data;
    } tword_t;
endpackage

// File: rtl/dbgf_decode.sv
// Module: host access decoder.
// Turns the word address and the strobes into one-hot push and pop requests.
// Assumes bit 5 of the word address is the write tag and bits 4:2 the select.
// A read wins over a simultaneous write; nothing is requested outside debug mode.
module dbgf_decode
    import dbgf_pkg::*;
#(
    parameter int N_FIFO = NUM_FIFO
) (
    input  logic              dbg_mode,
    input  logic [5:2]        hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    output logic [N_FIFO-1:0] push_req,
    output logic [N_FIFO-1:0] pop_req,
    output logic              wr_tag
);
    logic [SEL_W-1:0] sel;
    logic             rd_ok;
    logic             wr_ok;

    // Qualify the strobes with debug mode and read priority.
    always_comb begin
        sel    = hst_addr[4:2];
        wr_tag = hst_addr[5];
        rd_ok  = dbg_mode && hst_rd;
        wr_ok  = dbg_mode && hst_wr && !hst_rd;
    end

    // Expand the select code to one-hot requests; unmapped codes match nothing.
    always_comb begin
        for (int i = 0; i < N_FIFO; i++) begin
            push_req[i] = wr_ok && (sel == SEL_W'(i));
            pop_req[i]  = rd_ok && (sel == SEL_W'(i));
        end
    end
endmodule

// File: rtl/dbgf_tagfifo.sv
// Module: single-clock FIFO of 33-bit tagged words.
// Assumes the caller pops only when not empty; pushes while full are dropped here.
// The head word is presented combinationally on dout.
module dbgf_tagfifo
    import dbgf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  tword_t din,
    output tword_t dout,
    output logic   empty,
    output logic   full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    tword_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    // Status flags and the qualified push and pop.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Storage write; no reset is needed on the array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/dbgf_rd_stage.sv
// Module: read-return register and tag latch.
// Registers the popped data for one cycle, and zero when nothing was popped.
// The tag is held until the next pop overwrites it.
module dbgf_rd_stage
    import dbgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop_any,
    input  tword_t            pop_word,
    output logic [DATA_W-1:0] rdata,
    output logic              tag_q
);
    // Return data: the popped word for one cycle, otherwise zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (pop_any) rdata <= pop_word.data;
        else              rdata <= '0;
    end

    // Tag latch: updated only by a read that pops a word.
    always_ff @(posedge clk) begin
        if (!rst_n)       tag_q <= 1'b0;
        else if (pop_any) tag_q <= pop_word.tag;
    end
endmodule

// File: rtl/dbg_fifo_port.sv
// Module: debug FIFO bypass access port (top).
// Holds six tagged FIFOs: codes 0-2 transmit, code 3 combined receive,
// codes 4-5 receive sub-FIFOs. Host writes push a word with the address tag,
// host reads pop a word and latch its tag into status bit 6.
// Debug mode gates the normal arbitration requests low.
module dbg_fifo_port
    import dbgf_pkg::*;
#(
    parameter int TX_DEPTH      = 64,
    parameter int RX_COMB_DEPTH = 128,
    parameter int RX_SUB_DEPTH  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_mode,
    input  logic [5:2]  hst_addr,
    input  logic        hst_wr,
    input  logic        hst_rd,
    input  logic [31:0] hst_wdata,
    output logic [31:0] hst_rdata,
    output logic [31:0] stat_reg,
    output logic        arb_req_tx,
    output logic        arb_req_rx
);
    logic [NUM_FIFO-1:0] push_req;
    logic [NUM_FIFO-1:0] pop_req;
    logic [NUM_FIFO-1:0] pop_oh;
    logic [NUM_FIFO-1:0] f_empty;
    logic [NUM_FIFO-1:0] f_full;
    logic                wr_tag;
    tword_t              wr_word;
    tword_t              f_dout [NUM_FIFO];
    tword_t              pop_word;
    logic                pop_any;
    logic                tag_q;

    dbgf_decode #(.N_FIFO(NUM_FIFO)) u_decode (
        .dbg_mode (dbg_mode),
        .hst_addr (hst_addr),
        .hst_wr   (hst_wr),
        .hst_rd   (hst_rd),
        .push_req (push_req),
        .pop_req  (pop_req),
        .wr_tag   (wr_tag)
    );

    // Assemble the 33-bit entry from the bus word and the address tag.
    always_comb begin
        wr_word.tag  = wr_tag;
        wr_word.data = hst_wdata;
    end

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_fifo
        localparam int G_DEPTH = (g < TX_COUNT)  ? TX_DEPTH :
                                 (g == TX_COUNT) ? RX_COMB_DEPTH : RX_SUB_DEPTH;
        dbgf_tagfifo #(.DEPTH(G_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_req[g]),
            .pop   (pop_oh[g]),
            .din   (wr_word),
            .dout  (f_dout[g]),
            .empty (f_empty[g]),
            .full  (f_full[g])
        );
    end

    // Pop only a FIFO that holds a word, and pick its head.
    always_comb begin
        pop_oh   = pop_req & ~f_empty;
        pop_any  = |pop_oh;
        pop_word = '0;
        for (int i = 0; i < NUM_FIFO; i++) begin
            if (pop_oh[i]) pop_word = f_dout[i];
        end
    end

    dbgf_rd_stage u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_any  (pop_any),
        .pop_word (pop_word),
        .rdata    (hst_rdata),
        .tag_q    (tag_q)
    );

    // Status word with the latched tag at its bit position.
    always_comb begin
        stat_reg           = '0;
        stat_reg[STAT_TAG] = tag_q;
    end

    // Normal-side requests, held low in debug mode.
    always_comb begin
        arb_req_tx = !dbg_mode && !(&f_empty[TX_COUNT-1:0]);
        arb_req_rx = !dbg_mode && !(&f_empty[NUM_FIFO-1:TX_COUNT]);
    end
endmodule

// File: rtl/dbgf_port_chk.sv
// Checker: temporal properties of the debug FIFO port, observed at its ports.
module dbgf_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dbg_mode,
    input logic [5:2]  hst_addr,
    input logic        hst_rd,
    input logic [31:0] hst_rdata,
    input logic [31:0] stat_reg,
    input logic        arb_req_tx,
    input logic        arb_req_rx
);
    // R11: no read request, so no data on the next cycle.
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rd |=> hst_rdata == 32'd0);

    // R8: reads outside debug mode return zero.
    a_r8_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |=> hst_rdata == 32'd0);

    // R8 and R4: the status word moves only after a debug read.
    a_r4_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_rd && dbg_mode) |=> $stable(stat_reg));

    // R7: unmapped select codes read as zero.
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && hst_addr[4:3] == 2'b11) |=> hst_rdata == 32'd0);

    // R3: only status bit 6 may be set.
    a_r3_stat_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat_reg & ~32'h40) == 0);

    // R9: debug mode blocks both requests.
    a_r9_tx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !arb_req_tx);
    a_r9_rx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode |-> !arb_req_rx);
endmodule

bind dbg_fifo_port dbgf_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_mode   (dbg_mode),
    .hst_addr   (hst_addr),
    .hst_rd     (hst_rd),
    .hst_rdata  (hst_rdata),
    .stat_reg   (stat_reg),
    .arb_req_tx (arb_req_tx),
    .arb_req_rx (arb_req_rx)
);

// File: tb/dbg_fifo_port_bench.sv
// Bench: fills and drains every select code of a shrunken configuration
// and compares against a queue model built from the requirements.
module dbg_fifo_port_bench;
    localparam int TXD = 4;
    localparam int RXC = 8;
    localparam int RXS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [5:2]  hst_addr = '0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic [31:0] stat_reg;
    logic        arb_req_tx;
    logic        arb_req_rx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [32:0] mq [8][$];
    logic exp_tag = 1'b0;

    always #4 clk = ~clk;

    dbg_fifo_port #(.TX_DEPTH(TXD), .RX_COMB_DEPTH(RXC), .RX_SUB_DEPTH(RXS)) u_dbg_fifo_port (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .hst_addr(hst_addr),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .stat_reg(stat_reg),
        .arb_req_tx(arb_req_tx), .arb_req_rx(arb_req_rx)
    );

    function automatic int dep(int code);
        if (code < 3) return TXD;
        if (code == 3) return RXC;
        if (code < 6) return RXS;
        return 0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Push one word; model applies R6/R7/R8.
    task automatic hwrite(int code, bit tag, logic [31:0] d);
        hst_addr = {tag, 3'(code)};
        hst_wdata = d;
        hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
        if (dbg_mode && dep(code) > 0 && mq[code].size() < dep(code))
            mq[code].push_back({tag, d});
    endtask

    // Pop one word and check data and tag one cycle later (R3, R5, R7, R8).
    task automatic hread(int code, string req);
        logic [31:0] exp_d = '0;
        hst_addr = {1'b0, 3'(code)};
        hst_rd = 1'b1;
        if (dbg_mode && mq[code].size() > 0) begin
            logic [32:0] w = mq[code].pop_front();
            exp_d = w[31:0];
            exp_tag = w[32];
        end
        @(negedge clk);
        hst_rd = 1'b0;
        check(req, hst_rdata, exp_d);
        check("R3/R4 stat", stat_reg, {25'd0, exp_tag, 6'd0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset rdata", hst_rdata, 0);
        check("R3 reset stat", stat_reg, 0);
        check("R9 reset req", {30'd0, arb_req_tx, arb_req_rx}, 0);

        // R8: accesses while debug mode is low are ignored.
        hwrite(1, 1'b1, 32'hDEAD0001);
        hread(1, "R8 off read");
        dbg_mode = 1'b1;
        @(negedge clk);
        hread(1, "R8 off write not stored");

        // R1 R2 R6 R7: fill every code past its depth with alternating tags.
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < dep(c) + 2; i++) begin
                hwrite(c, bit'((i ^ c) & 1), 32'h5A000000 ^ (c << 20) ^ (i * 32'h00010101));
            end
        end
        check("R9 blocked in debug", {30'd0, arb_req_tx, arb_req_rx}, 0);

        // R9: requests rise when debug mode drops; R8 read ignored.
        dbg_mode = 1'b0;
        @(negedge clk);
        check("R9 tx req", {31'd0, arb_req_tx}, 1);
        check("R9 rx req", {31'd0, arb_req_rx}, 1);
        hread(0, "R8 off read of full fifo");
        dbg_mode = 1'b1;
        @(negedge clk);

        // R1 R2 R5 R6 R7: drain every code past empty.
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < dep(c) + 2; i++) begin
                hread(c, (c > 5) ? "R7 unmapped" : (i >= dep(c)) ? "R5 empty" : "R1/R6 order");
            end
        end

        // R4: tag holds over idle cycles.
        repeat (5) @(negedge clk);
        check("R4 tag hold", stat_reg, {25'd0, exp_tag, 6'd0});
        check("R11 idle zero", hst_rdata, 0);

        // R10: read and write together; only the read takes effect.
        hwrite(4, 1'b1, 32'h01234567);
        hst_addr = {1'b0, 3'd4};
        hst_wdata = 32'h89ABCDEF;
        hst_wr = 1'b1;
        hst_rd = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
        hst_rd = 1'b0;
        void'(mq[4].pop_front());
        exp_tag = 1'b1;
        check("R10 read wins", hst_rdata, 32'h01234567);
        check("R10 tag", stat_reg, 32'h40);
        hread(4, "R10 write discarded");

        // R9: all empty, requests stay low after debug drops.
        dbg_mode = 1'b0;
        @(negedge clk);
        check("R9 empty no req", {30'd0, arb_req_tx, arb_req_rx}, 0);

        // R9: a single rx word raises rx only.
        dbg_mode = 1'b1;
        @(negedge clk);
        hwrite(5, 1'b0, 32'hCAFE0005);
        dbg_mode = 1'b0;
        @(negedge clk);
        check("R9 rx only", {30'd0, arb_req_tx, arb_req_rx}, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule